// File: doc/BRIEF.md
# Windowed Key-Protected Watchdog Timer

This block is a secondary watchdog for a processor subsystem. A down counter, 12 bits wide by default, is decremented once for every 128 enabled ticks of a slow clock. The `tick_en` strobe stands in for that slow clock. Software keeps the counter from running out by issuing a restart command. The command carries a fixed key in its top byte, and it is honoured only while the counter has fallen to or below a programmed window value. An early restart is a fault in its own right.

Two sticky events are recorded: counter underflow and window violation. Each is cleared by reading the status word. Both feed a fault line meant for the reset controller and an interrupt line, and each line has its own enable. The configuration word is written at most once after reset, which loads the counter with the new reload value. The configuration can also make the count pause while the processor reports debug or idle state.

Top module: `win_watchdog`

## Requirements
- R1: Reset state:
  - The counter holds all ones and both status flags are clear.
  - `fault_o` and `irq_o` are low.
  - The configuration word reads 0x02FFFFFF: reload all ones, window all ones, fault enable set, and interrupt and both halt enables clear.
  - The configuration is unlocked.
- R2: While not halted, the counter drops by one every PRESC ticks. A count step taken at a value of 1 or 0 is an underflow. An underflow sets the underflow flag (status bit 0) and reloads the counter with the reload field. The counter then keeps running, so underflow comes max(reload,1)*PRESC ticks after a load.
- R3: A restart is a write to address 0 with 0xC4 in bits [31:24] and bit 0 set. When the counter is at or below the window field, a restart reloads the counter and restarts the prescaler.
- R4: A restart while the counter is above the window field sets the window-error flag (status bit 1) and leaves the counter unchanged.
- R5: A write to address 0 with any other key value, or with bit 0 clear, changes neither the counter nor the flags.
- R6: Configuration word at address 1:
  - Fields: reload [11:0], window [23:12], interrupt enable [24], fault enable [25], debug-halt enable [26], idle-halt enable [27].
  - The first write after reset stores it, loads the counter with the new reload value and clears the prescaler.
  - Every later write is ignored.
- R7: Reading address 2 with `rd_en` returns {window error, underflow} in bits [1:0]. The read clears both flags unless a new event arrives in the same cycle.
- R8: `fault_o` is high while a flag is set and the fault enable is 1. `irq_o` is high while a flag is set and the interrupt enable is 1.
- R9: While `dbg_halt` is high with the debug-halt enable set, or `idle_halt` is high with the idle-halt enable set, ticks are ignored and the counter holds.
- R10: Address 3 reads the current counter value, address 1 reads the stored configuration, and address 0 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle strobe per slow-clock tick |
| dbg_halt | input | 1 | Processor is in debug state |
| idle_halt | input | 1 | Processor is idle |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status on address 2) |
| addr | input | 2 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| fault_o | output | 1 | Fault request to the reset controller |
| irq_o | output | 1 | Fault interrupt |

## Verification
The bound checker watches these properties on every cycle:
- The counter never exceeds the stored reload value.
- An underflow reloads the counter and raises its flag.
- A halt freezes the count.
- A locked configuration stays fixed.
- A wrong key never raises the window error.
- A status read clears the flags when no new event arrives.
- Both outputs are low while no flag is set.

Only the bench scenarios can show the exact underflow period for each reload value, the accept or reject decision over every pairing of counter value and window, and the gating of the outputs by their enables. The bench uses a 4-bit counter with a divide-by-4 prescaler, so these sweeps are exhaustive.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam logic [7:0] RESTART_KEY = 8'hC4;
    localparam int         FIELD_W     = 12;

    typedef enum logic [1:0] {
        ADR_CTRL  = 2'd0,
        ADR_CFG   = 2'd1,
        ADR_STAT  = 2'd2,
        ADR_COUNT = 2'd3
    } wdg_addr_e;

    // Configuration word; packed from the top bit down.
    typedef struct packed {
        logic               idle_stop;
        logic               dbg_stop;
        logic               fault_en;
        logic               irq_en;
        logic [FIELD_W-1:0] window;
        logic [FIELD_W-1:0] reload;
    } wdg_cfg_t;

    typedef struct packed {
        logic win_err;
        logic under;
    } wdg_flags_t;

    function automatic wdg_cfg_t cfg_default();
        wdg_cfg_t c;
        c.idle_stop = 1'b0;
        c.dbg_stop  = 1'b0;
        c.fault_en  = 1'b1;
        c.irq_en    = 1'b0;
        c.window    = '1;
        c.reload    = '1;
        return c;
    endfunction

    function automatic logic is_restart(input logic [31:0] w);
        return (w[31:24] == RESTART_KEY) && w[0];
    endfunction

endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
    parameter int PRESC = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic halt,
    input  logic clear,
    output logic step
);
    localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESC - 1);

    logic [PW-1:0] phase;
    logic          live;

    assign live = tick_en && !halt;
    assign step = live && (phase == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            phase <= '0;
        end else if (live) begin
            phase <= step ? '0 : phase + 1'b1;
        end
    end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             under_evt
);
    logic at_end;

    assign at_end    = (count <= CNT_W'(1));
    assign under_evt = step && !load && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '1;
        end else if (load) begin
            count <= load_val;
        end else if (step) begin
            count <= at_end ? reload_val : count - 1'b1;
        end
    end
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [31:0]      wdata,
    input  logic [CNT_W-1:0] count,
    input  logic             under_evt,
    output wdg_cfg_t         cfg,
    output logic             locked,
    output wdg_flags_t       flags,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             err_evt,
    output logic [31:0]      rdata
);
    wdg_addr_e  sel;
    logic       restart, in_window, accept, cfg_wr, stat_rd;
    wdg_flags_t kept, events;

    assign sel       = wdg_addr_e'(addr);
    assign restart   = wr_en && (sel == ADR_CTRL) && is_restart(wdata);
    assign in_window = (count <= cfg.window[CNT_W-1:0]);
    assign accept    = restart && in_window;
    assign err_evt   = restart && !in_window;
    assign cfg_wr    = wr_en && (sel == ADR_CFG) && !locked;
    assign stat_rd   = rd_en && (sel == ADR_STAT);
    assign load      = accept || cfg_wr;
    assign load_val  = cfg_wr ? wdata[CNT_W-1:0] : cfg.reload[CNT_W-1:0];

    assign events.win_err = err_evt;
    assign events.under   = under_evt;
    assign kept           = stat_rd ? '0 : flags;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= cfg_default();
            locked <= 1'b0;
            flags  <= '0;
        end else begin
            if (cfg_wr) begin
                cfg    <= wdg_cfg_t'(wdata[$bits(wdg_cfg_t)-1:0]);
                locked <= 1'b1;
            end
            flags <= kept | events;
        end
    end

    always_comb begin
        unique case (sel)
            ADR_CFG:   rdata = 32'(cfg);
            ADR_STAT:  rdata = 32'(flags);
            ADR_COUNT: rdata = 32'(count);
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
    import wdg_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int PRESC = 128
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_en,
    input  logic        dbg_halt,
    input  logic        idle_halt,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [1:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        fault_o,
    output logic        irq_o
);
    wdg_cfg_t         cfg;
    wdg_flags_t       flags;
    logic             locked, load, err_evt, under_evt, step, halt, any_flag;
    logic [CNT_W-1:0] count, load_val;

    assign halt = (dbg_halt && cfg.dbg_stop) || (idle_halt && cfg.idle_stop);

    wdg_prescaler #(.PRESC(PRESC)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .halt    (halt),
        .clear   (load),
        .step    (step)
    );

    wdg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .load_val   (load_val),
        .reload_val (cfg.reload[CNT_W-1:0]),
        .step       (step),
        .count      (count),
        .under_evt  (under_evt)
    );

    wdg_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .count     (count),
        .under_evt (under_evt),
        .cfg       (cfg),
        .locked    (locked),
        .flags     (flags),
        .load      (load),
        .load_val  (load_val),
        .err_evt   (err_evt),
        .rdata     (rdata)
    );

    assign any_flag = |flags;
    assign fault_o  = any_flag && cfg.fault_en;
    assign irq_o    = any_flag && cfg.irq_en;
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             rd_en,
    input logic [1:0]       addr,
    input logic [31:0]      wdata,
    input logic [CNT_W-1:0] count,
    input logic [27:0]      cfg_bits,
    input logic             locked,
    input logic [1:0]       flag_bits,
    input logic             under_evt,
    input logic             err_evt,
    input logic             load,
    input logic             halt,
    input logic             fault_o,
    input logic             irq_o
);
    logic [CNT_W-1:0] reload_lo;
    assign reload_lo = cfg_bits[CNT_W-1:0];

    assert_cnt_bounded_R2: assert property (@(posedge clk) disable iff (rst)
        count <= reload_lo);

    assert_under_reload_R2: assert property (@(posedge clk) disable iff (rst)
        (under_evt && !load) |=> (flag_bits[0] && count == $past(reload_lo)));

    assert_early_err_R4: assert property (@(posedge clk) disable iff (rst)
        err_evt |=> flag_bits[1]);

    assert_badkey_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd0 && wdata[31:24] != 8'hC4) |=> !$rose(flag_bits[1]));

    assert_cfg_locked_R6: assert property (@(posedge clk) disable iff (rst)
        (locked && wr_en && addr == 2'd1) |=> $stable(cfg_bits));

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 2'd2 && !under_evt && !err_evt) |=> (flag_bits == 2'b00));

    assert_quiet_outputs_R8: assert property (@(posedge clk) disable iff (rst)
        (flag_bits == 2'b00) |-> (!fault_o && !irq_o));

    assert_halt_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (halt && !load) |=> $stable(count));
endmodule

bind win_watchdog wdg_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .count     (count),
    .cfg_bits  (cfg),
    .locked    (locked),
    .flag_bits (flags),
    .under_evt (under_evt),
    .err_evt   (err_evt),
    .load      (load),
    .halt      (halt),
    .fault_o   (fault_o),
    .irq_o     (irq_o)
);

// File: tb/tb_win_watchdog.sv
module tb_win_watchdog;
    localparam int CW = 4;
    localparam int PS = 4;
    localparam int TOP = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b1, dbg_halt = 1'b0, idle_halt = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        fault_o, irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    win_watchdog #(.CNT_W(CW), .PRESC(PS)) dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .dbg_halt(dbg_halt),
        .idle_halt(idle_halt), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .fault_o(fault_o), .irq_o(irq_o)
    );

    function automatic logic [31:0] cfg_word(input int rl, input int win, input bit ien,
                                             input bit fen, input bit dstop, input bit istop);
        return {4'b0, istop, dstop, fen, ien, 12'(win), 12'(rl)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; wr_en = 0; rd_en = 0; dbg_halt = 0; idle_halt = 0; tick_en = 1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [31:0] v);
        addr = a; #1 v = rdata;
    endtask

    task automatic read_stat(output logic [31:0] v);
        addr = 2'd2; rd_en = 1'b1; #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        @(negedge clk);
        do_reset();

        // R1 reset state
        peek(2'd3, v); check("R1 count", v, 32'(TOP));
        peek(2'd2, v); check("R1 flags", v, 0);
        peek(2'd1, v); check("R1 cfg", v, 32'h02FF_FFFF);
        peek(2'd0, v); check("R10 ctrl reads zero", v, 0);
        check("R1 fault", 32'(fault_o), 0);
        check("R1 irq", 32'(irq_o), 0);

        // R2 underflow period sweep for every reload value
        for (int rl = 0; rl <= TOP; rl++) begin
            int per;
            per = ((rl < 1) ? 1 : rl) * PS;
            do_reset();
            wr(2'd1, cfg_word(rl, TOP, 0, 1, 0, 0));
            peek(2'd3, v); check("R6 load on cfg write", v, 32'(rl));
            wait_cyc(per - 1);
            peek(2'd2, v); check("R2 no underflow early", v, 0);
            wait_cyc(1);
            peek(2'd2, v); check("R2 underflow flag", v, 1);
            peek(2'd3, v); check("R2 reload after underflow", v, 32'(rl));
            check("R8 fault on underflow", 32'(fault_o), 1);
        end

        // R3 / R4 window sweep over every window and counter value
        for (int d = 0; d <= TOP; d++) begin
            for (int k = 0; k < TOP; k++) begin
                bit early;
                early = ((TOP - k) > d);
                do_reset();
                wr(2'd1, cfg_word(TOP, d, 0, 0, 0, 0));
                wait_cyc(k * PS);
                wr(2'd0, 32'hC400_0001);
                peek(2'd3, v);
                if (early) check("R4 count kept", v, 32'(TOP - k));
                else       check("R3 count reloaded", v, 32'(TOP));
                peek(2'd2, v);
                check(early ? "R4 error flag" : "R3 no error", v, early ? 2 : 0);
            end
        end

        // R3 prescaler restart: next step a full PS ticks after accept
        do_reset();
        wr(2'd1, cfg_word(TOP, TOP, 0, 0, 0, 0));
        wait_cyc(2);
        wr(2'd0, 32'hC400_0001);
        wait_cyc(PS - 1);
        peek(2'd3, v); check("R3 prescaler cleared", v, 32'(TOP));
        wait_cyc(1);
        peek(2'd3, v); check("R3 first step after restart", v, 32'(TOP - 1));

        // R5 wrong key / missing command bit
        do_reset();
        wr(2'd1, cfg_word(TOP, TOP, 0, 0, 0, 0));
        wait_cyc(3 * PS);
        wr(2'd0, 32'hC300_0001);
        peek(2'd3, v); check("R5 bad key count", v, 32'(TOP - 3));
        peek(2'd2, v); check("R5 bad key flags", v, 0);
        wr(2'd0, 32'hC400_0000);
        peek(2'd3, v); check("R5 bit0 clear count", v, 32'(TOP - 3));
        peek(2'd2, v); check("R5 bit0 clear flags", v, 0);

        // R6 configuration locks after first write
        do_reset();
        wr(2'd1, cfg_word(10, TOP, 0, 1, 0, 0));
        wr(2'd1, cfg_word(5, 3, 1, 0, 1, 1));
        peek(2'd1, v); check("R6 cfg locked", v, cfg_word(10, TOP, 0, 1, 0, 0));
        peek(2'd3, v); check("R6 no reload on ignored write", v, 10);

        // R7 / R8 interrupt path and clear on read
        do_reset();
        wr(2'd1, cfg_word(2, TOP, 1, 0, 0, 0));
        wait_cyc(2 * PS);
        check("R8 irq on underflow", 32'(irq_o), 1);
        check("R8 fault gated off", 32'(fault_o), 0);
        read_stat(v); check("R7 status value", v, 1);
        peek(2'd2, v); check("R7 flags cleared", v, 0);
        check("R8 irq drops after clear", 32'(irq_o), 0);

        // R4 / R8 early restart drives fault
        do_reset();
        wr(2'd1, cfg_word(TOP, 3, 0, 1, 0, 0));
        wr(2'd0, 32'hC400_0001);
        check("R8 fault on window error", 32'(fault_o), 1);
        check("R8 irq gated off", 32'(irq_o), 0);
        read_stat(v); check("R7 window error reported", v, 2);

        // R9 halts
        do_reset();
        wr(2'd1, cfg_word(TOP, TOP, 0, 0, 1, 0));
        dbg_halt = 1'b1;
        wait_cyc(10 * PS);
        peek(2'd3, v); check("R9 debug halt holds", v, 32'(TOP));
        dbg_halt = 1'b0; idle_halt = 1'b1;
        wait_cyc(2 * PS);
        peek(2'd3, v); check("R9 idle without enable counts", v, 32'(TOP - 2));
        idle_halt = 1'b0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule